// File: doc/BRIEF.md
# Sleep Wake-Source and Sleep-Refusal Controller

This block decides when a sleeping chip should wake and whether a request to enter sleep should be refused. It gathers eleven wake sources and qualifies each one by a per-source enable bit and by the sleep depth in force. The sources are two external pad groups, two serial receive lines, and seven event lines from other peripherals. While the chip sleeps, the first qualified source ends the sleep with a one-cycle wake pulse and a recorded cause vector.

When software asks for sleep, the block checks which enabled non-serial sources are active at that moment. If refusal is enabled for the requested depth and any such source is active, the block refuses the request. It raises a one-cycle refusal pulse and records the cause, and the chip never leaves the awake state.

The block also contains the pad logic. The single-pad source picks one pad and checks it against a polarity bit. The multi-pad source takes a bitmap and uses any-high or all-low logic. Each serial line has a rising-edge counter that must reach a programmable threshold plus two.

Top module: `wake_reject_ctrl`

## Requirements
- R1: After reset, `asleep`, `wake`, `reject`, `wake_cause` and `reject_cause` are all zero.
- R2: Source bit positions in `wake_en` and in both cause vectors are: bit0 single-pad, bit1 multi-pad, bit2 GPIO, bit3 timer, bit4 SDIO, bit5 Wi-Fi, bit6 serial 0, bit7 serial 1, bit8 touch, bit9 coprocessor, bit10 BT. Every source is valid in light sleep (`sleep_mode`=1). Only bits 0,1,2,3,8,9 are valid in deep sleep (`sleep_mode`=2). Only bits 1 and 3 are valid in hibernation (`sleep_mode`=3).
- R3: The single-pad source is active when `ext0_pads[ext0_sel]` equals `ext0_pol`, so pol 1 means high level and pol 0 means low level.
- R4: With `ext1_pol`=1, the multi-pad source is active when any pad selected in `ext1_map` is high. With `ext1_pol`=0, it is active when every selected pad is low. An all-zero map never activates it.
- R5: A serial source is active once the number of rising edges on its receive line during the current sleep reaches `uart_thresh`+2. Each counter clears when a sleep request is accepted.
- R6: While asleep, any enabled source that is valid for the latched mode ends the sleep. On the next clock `wake` pulses for one cycle, `wake_cause` holds the qualifying sources, and `asleep` drops. While awake, sources raise no wake.
- R7: Suppose a request (`sleep_req` with `sleep_mode`≠0, while awake) arrives with refusal enabled for that mode, and some enabled source valid in that mode and other than bits 6 and 7 is active. Then on the next clock `reject` pulses for one cycle, `reject_cause` holds those sources, and `asleep` stays 0.
- R8: `rej_light_en` gates refusal of light sleep. `rej_deep_en` gates refusal of both deep sleep and hibernation. With the gate off, the request is accepted and `asleep` rises on the next clock.
- R9: The serial sources never cause a refusal, even when active and enabled.
- R10: A request made while asleep, or with `sleep_mode`=0, changes neither `asleep` nor `reject`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_en | input | 11 | Per-source enable mask |
| sleep_mode | input | 2 | Requested depth: 0 none, 1 light, 2 deep, 3 hibernation |
| sleep_req | input | 1 | Sleep request strobe |
| rej_light_en | input | 1 | Enable refusal of light sleep |
| rej_deep_en | input | 1 | Enable refusal of deep sleep and hibernation |
| ext0_pads | input | 32 | Pad levels for the single-pad source |
| ext0_sel | input | 5 | Pad index for the single-pad source |
| ext0_pol | input | 1 | Active level for the single-pad source |
| ext1_pads | input | 18 | Pad levels for the multi-pad source |
| ext1_map | input | 18 | Pad bitmap for the multi-pad source |
| ext1_pol | input | 1 | 1 any-high, 0 all-low |
| uart_rxd | input | 2 | Serial receive lines |
| uart_thresh | input | 10 | Edge threshold (wake at value+2) |
| gpio_evt | input | 1 | GPIO wake event |
| timer_evt | input | 1 | Timer wake event |
| sdio_evt | input | 1 | SDIO command event |
| wifi_evt | input | 1 | Wi-Fi event |
| touch_evt | input | 1 | Touch event |
| cop_evt | input | 1 | Coprocessor event |
| bt_evt | input | 1 | BT event |
| asleep | output | 1 | Sleep state |
| wake | output | 1 | One-cycle wake pulse |
| wake_cause | output | 11 | Sources that caused the last wake |
| reject | output | 1 | One-cycle refusal pulse |
| reject_cause | output | 11 | Sources that caused the last refusal |

## Verification
Four properties hold on every cycle:
- a wake pulse only ends a sleep, and its cause is non-empty and legal for the latched mode;
- a refusal never names a serial source, always leaves the chip awake, and only follows a request whose mode had refusal enabled;
- a request made while asleep leaves the state alone;
- the edge counters only move upward, one step at a time, between clears.

Other behaviour only the scenarios can show. This covers the pad selection and polarity, the any-high and all-low multi-pad rules with an empty map, and the exact edge at which the threshold plus two is reached. It also covers the counter clearing on sleep entry and the per-mode filtering of which sources may wake or refuse.

// File: rtl/wkr_pkg.sv
package wkr_pkg;
    localparam int NSRC  = 11;
    localparam int NUART = 2;

    localparam int S_EXT0  = 0;
    localparam int S_EXT1  = 1;
    localparam int S_GPIO  = 2;
    localparam int S_TIMER = 3;
    localparam int S_SDIO  = 4;
    localparam int S_WIFI  = 5;
    localparam int S_UART0 = 6;
    localparam int S_TOUCH = 8;
    localparam int S_COP   = 9;
    localparam int S_BT    = 10;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef enum logic [1:0] {
        MODE_AWAKE = 2'd0,
        MODE_LIGHT = 2'd1,
        MODE_DEEP  = 2'd2,
        MODE_HIBER = 2'd3
    } slp_mode_e;

    localparam src_vec_t UART_MASK = src_vec_t'(11'h0C0);

    typedef struct packed {
        logic     refuse;
        src_vec_t cause;
    } refusal_t;

    function automatic src_vec_t mode_allow(slp_mode_e m);
        src_vec_t v;
        case (m)
            MODE_LIGHT: v = '1;
            MODE_DEEP:  v = src_vec_t'(11'h30F);
            MODE_HIBER: v = src_vec_t'(11'h00A);
            default:    v = '0;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/ext_pad_detect.sv
module ext_pad_detect #(
    parameter int EXT0_N = 32,
    parameter int EXT1_N = 18,
    localparam int SELW  = $clog2(EXT0_N)
) (
    input  logic [EXT0_N-1:0] ext0_pads,
    input  logic [SELW-1:0]   ext0_sel,
    input  logic              ext0_pol,
    input  logic [EXT1_N-1:0] ext1_pads,
    input  logic [EXT1_N-1:0] ext1_map,
    input  logic              ext1_pol,
    output logic              ext0_hit,
    output logic              ext1_hit
);
    logic [EXT1_N-1:0] picked;
    logic              any_high;
    logic              all_low;

    always_comb begin
        ext0_hit = (ext0_pads[ext0_sel] == ext0_pol);
        picked   = ext1_pads & ext1_map;
        any_high = |picked;
        all_low  = (ext1_map != '0) && (picked == '0);
        ext1_hit = ext1_pol ? any_high : all_low;
    end
endmodule

// File: rtl/uart_edge_cnt.sv
module uart_edge_cnt #(
    parameter int THR_W = 10,
    localparam int CNT_W = THR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             run,
    input  logic             rxd,
    input  logic [THR_W-1:0] thresh,
    output logic             reached
);
    logic             rxd_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] target;

    always_ff @(posedge clk) begin
        if (rst) begin
            rxd_q <= 1'b0;
            cnt   <= '0;
        end else begin
            rxd_q <= rxd;
            if (clr)
                cnt <= '0;
            else if (run && rxd && !rxd_q && cnt != '1)
                cnt <= cnt + 1'b1;
        end
    end

    assign target  = {1'b0, thresh} + CNT_W'(2);
    assign reached = (cnt >= target);

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (cnt >= $past(cnt)) && ((cnt - $past(cnt)) <= CNT_W'(1)));
endmodule

// File: rtl/wake_reject_ctrl.sv
module wake_reject_ctrl
    import wkr_pkg::*;
#(
    parameter int EXT0_N = 32,
    parameter int EXT1_N = 18,
    parameter int THR_W  = 10,
    localparam int SELW  = $clog2(EXT0_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   wake_en,
    input  logic [1:0]        sleep_mode,
    input  logic              sleep_req,
    input  logic              rej_light_en,
    input  logic              rej_deep_en,
    input  logic [EXT0_N-1:0] ext0_pads,
    input  logic [SELW-1:0]   ext0_sel,
    input  logic              ext0_pol,
    input  logic [EXT1_N-1:0] ext1_pads,
    input  logic [EXT1_N-1:0] ext1_map,
    input  logic              ext1_pol,
    input  logic [NUART-1:0]  uart_rxd,
    input  logic [THR_W-1:0]  uart_thresh,
    input  logic              gpio_evt,
    input  logic              timer_evt,
    input  logic              sdio_evt,
    input  logic              wifi_evt,
    input  logic              touch_evt,
    input  logic              cop_evt,
    input  logic              bt_evt,
    output logic              asleep,
    output logic              wake,
    output logic [NSRC-1:0]   wake_cause,
    output logic              reject,
    output logic [NSRC-1:0]   reject_cause
);
    logic             ext0_hit, ext1_hit;
    logic [NUART-1:0] uart_hit;
    src_vec_t         raw, hit;
    slp_mode_e        mode_q, req_mode;
    logic             asleep_q, req_ok, rej_on, enter_sleep;
    refusal_t         ref_chk;

    ext_pad_detect #(.EXT0_N(EXT0_N), .EXT1_N(EXT1_N)) u_pads (
        .ext0_pads(ext0_pads), .ext0_sel(ext0_sel), .ext0_pol(ext0_pol),
        .ext1_pads(ext1_pads), .ext1_map(ext1_map), .ext1_pol(ext1_pol),
        .ext0_hit(ext0_hit), .ext1_hit(ext1_hit)
    );

    for (genvar u = 0; u < NUART; u++) begin : g_uart
        uart_edge_cnt #(.THR_W(THR_W)) u_cnt (
            .clk(clk), .rst(rst), .clr(enter_sleep), .run(asleep_q),
            .rxd(uart_rxd[u]), .thresh(uart_thresh), .reached(uart_hit[u])
        );
    end

    always_comb begin
        raw          = '0;
        raw[S_EXT0]  = ext0_hit;
        raw[S_EXT1]  = ext1_hit;
        raw[S_GPIO]  = gpio_evt;
        raw[S_TIMER] = timer_evt;
        raw[S_SDIO]  = sdio_evt;
        raw[S_WIFI]  = wifi_evt;
        raw[S_UART0 +: NUART] = uart_hit;
        raw[S_TOUCH] = touch_evt;
        raw[S_COP]   = cop_evt;
        raw[S_BT]    = bt_evt;
    end

    always_comb begin
        hit           = raw & wake_en & mode_allow(mode_q);
        req_mode      = slp_mode_e'(sleep_mode);
        req_ok        = sleep_req && !asleep_q && (req_mode != MODE_AWAKE);
        rej_on        = (req_mode == MODE_LIGHT) ? rej_light_en : rej_deep_en;
        ref_chk.cause = raw & wake_en & mode_allow(req_mode) & ~UART_MASK;
        ref_chk.refuse = req_ok && rej_on && (ref_chk.cause != '0);
        enter_sleep   = req_ok && !ref_chk.refuse;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            asleep_q     <= 1'b0;
            mode_q       <= MODE_AWAKE;
            wake         <= 1'b0;
            wake_cause   <= '0;
            reject       <= 1'b0;
            reject_cause <= '0;
        end else begin
            wake   <= 1'b0;
            reject <= 1'b0;
            if (asleep_q) begin
                if (hit != '0) begin
                    wake       <= 1'b1;
                    wake_cause <= hit;
                    asleep_q   <= 1'b0;
                end
            end else if (ref_chk.refuse) begin
                reject       <= 1'b1;
                reject_cause <= ref_chk.cause;
            end else if (enter_sleep) begin
                asleep_q     <= 1'b1;
                mode_q       <= req_mode;
                reject_cause <= '0;
            end
        end
    end

    assign asleep = asleep_q;

    // R6
    wake_ends_sleep_chk: assert property (@(posedge clk) disable iff (rst)
        wake |-> !asleep_q && $past(asleep_q));
    // R6
    wake_cause_legal_chk: assert property (@(posedge clk) disable iff (rst)
        wake |-> (wake_cause != '0) && ((wake_cause & ~mode_allow(mode_q)) == '0));
    // R9
    reject_no_uart_chk: assert property (@(posedge clk) disable iff (rst)
        reject |-> (reject_cause & UART_MASK) == '0);
    // R7
    reject_stays_awake_chk: assert property (@(posedge clk) disable iff (rst)
        reject |-> !asleep_q && !$past(asleep_q) && !wake);
    // R8
    reject_gated_chk: assert property (@(posedge clk) disable iff (rst)
        reject |-> (($past(sleep_mode) == 2'd1) ? $past(rej_light_en) : $past(rej_deep_en)));
    // R10
    req_asleep_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (asleep_q && sleep_req && hit == '0) |=> asleep_q && !reject);
endmodule

// File: tb/tb_wake_reject_ctrl.sv
module tb_wake_reject_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] wake_en = '0;
    logic [1:0]  sleep_mode = '0;
    logic        sleep_req = 1'b0, rej_light_en = 1'b0, rej_deep_en = 1'b0;
    logic [31:0] ext0_pads = '0;
    logic [4:0]  ext0_sel = '0;
    logic        ext0_pol = 1'b1;
    logic [17:0] ext1_pads = '0, ext1_map = '0;
    logic        ext1_pol = 1'b0;
    logic [1:0]  uart_rxd = '0;
    logic [9:0]  uart_thresh = '0;
    logic        gpio_evt = 0, timer_evt = 0, sdio_evt = 0, wifi_evt = 0;
    logic        touch_evt = 0, cop_evt = 0, bt_evt = 0;
    logic        asleep, wake, reject;
    logic [10:0] wake_cause, reject_cause;

    int nchk = 0, nerr = 0, wake_cnt = 0;
    logic [10:0] last_cause = '0;

    wake_reject_ctrl dut (
        .clk(clk), .rst(rst), .wake_en(wake_en), .sleep_mode(sleep_mode),
        .sleep_req(sleep_req), .rej_light_en(rej_light_en), .rej_deep_en(rej_deep_en),
        .ext0_pads(ext0_pads), .ext0_sel(ext0_sel), .ext0_pol(ext0_pol),
        .ext1_pads(ext1_pads), .ext1_map(ext1_map), .ext1_pol(ext1_pol),
        .uart_rxd(uart_rxd), .uart_thresh(uart_thresh),
        .gpio_evt(gpio_evt), .timer_evt(timer_evt), .sdio_evt(sdio_evt),
        .wifi_evt(wifi_evt), .touch_evt(touch_evt), .cop_evt(cop_evt), .bt_evt(bt_evt),
        .asleep(asleep), .wake(wake), .wake_cause(wake_cause),
        .reject(reject), .reject_cause(reject_cause)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        #2;
        if (wake === 1'b1) begin
            wake_cnt++;
            last_cause = wake_cause;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_src();
        wake_en = '0; gpio_evt = 0; timer_evt = 0; sdio_evt = 0; wifi_evt = 0;
        touch_evt = 0; cop_evt = 0; bt_evt = 0;
        ext0_pol = 1'b1; ext0_pads = '0; ext1_map = '0; ext1_pads = '0;
        uart_rxd = '0; rej_light_en = 0; rej_deep_en = 0;
    endtask

    task automatic request(logic [1:0] m);
        sleep_mode = m; sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
    endtask

    task automatic rx_pulse();
        uart_rxd[0] = 1'b1; @(negedge clk);
        uart_rxd[0] = 1'b0; @(negedge clk);
    endtask

    task automatic timer_wake(string req);
        int w0;
        w0 = wake_cnt;
        wake_en[3] = 1'b1; timer_evt = 1'b1;
        @(negedge clk);
        check(req, wake_cnt, w0 + 1);
        timer_evt = 1'b0;
    endtask

    function automatic logic [10:0] allow(logic [1:0] m);
        case (m)
            2'd1: return 11'h7FF;
            2'd2: return 11'h30F;
            2'd3: return 11'h00A;
            default: return 11'h000;
        endcase
    endfunction

    function automatic logic [10:0] model_raw();
        logic [10:0] r;
        r = '0;
        r[0]  = (ext0_pads[ext0_sel] == ext0_pol);
        r[1]  = ext1_pol ? ((ext1_pads & ext1_map) != 0)
                         : ((ext1_map != 0) && ((ext1_pads & ext1_map) == 0));
        r[2]  = gpio_evt;  r[3] = timer_evt; r[4] = sdio_evt; r[5] = wifi_evt;
        r[8]  = touch_evt; r[9] = cop_evt;   r[10] = bt_evt;
        return r;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int w0;
        void'($urandom(32'h1234abcd));
        tick(3);
        rst = 1'b0;
        @(negedge clk);
        check("R1 asleep", asleep, 0);
        check("R1 wake", wake, 0);
        check("R1 reject", reject, 0);
        check("R1 wake_cause", wake_cause, 0);
        check("R1 reject_cause", reject_cause, 0);

        // R3 single pad, high level
        clear_src(); wake_en = 11'h001; ext0_sel = 5'd5; ext0_pol = 1;
        ext0_pads = ~(32'h1 << 5);
        request(2'd2);
        check("R6 enter deep", asleep, 1);
        w0 = wake_cnt; tick(3);
        check("R3 other pads high no wake", wake_cnt, w0);
        ext0_pads[5] = 1'b1; @(negedge clk);
        check("R3 pad high wakes", wake_cnt, w0 + 1);
        check("R3 cause", last_cause, 11'h001);
        check("R6 awake after wake", asleep, 0);
        // R3 low level
        ext0_pol = 0; ext0_sel = 5'd9; ext0_pads = '1;
        request(2'd1);
        w0 = wake_cnt; tick(2);
        check("R3 pad high with pol0 no wake", wake_cnt, w0);
        ext0_pads[9] = 1'b0; @(negedge clk);
        check("R3 pad low wakes", wake_cnt, w0 + 1);

        // R4 all-low in hibernation
        clear_src(); wake_en = 11'h002; ext1_pol = 0; ext1_map = 18'h5; ext1_pads = 18'h4;
        request(2'd3);
        check("R4 enter hiber", asleep, 1);
        w0 = wake_cnt; tick(2);
        check("R4 one selected high no wake", wake_cnt, w0);
        ext1_pads = 18'h3FFFA; @(negedge clk);
        check("R4 all selected low wakes", wake_cnt, w0 + 1);
        check("R4 cause", last_cause, 11'h002);
        // R4 any-high
        ext1_pol = 1; ext1_map = 18'h30; ext1_pads = 18'h0F;
        request(2'd2);
        w0 = wake_cnt; tick(2);
        check("R4 unselected high no wake", wake_cnt, w0);
        ext1_pads[5] = 1'b1; @(negedge clk);
        check("R4 selected high wakes", wake_cnt, w0 + 1);
        // R4 empty map
        ext1_pol = 0; ext1_map = '0; ext1_pads = '0;
        request(2'd1);
        w0 = wake_cnt; tick(3);
        check("R4 empty map no wake", wake_cnt, w0);
        timer_wake("R4 timer exit");

        // R2 hibernation filter
        clear_src(); wake_en = 11'h7FF; ext0_pol = 0; ext0_pads = '1;
        request(2'd3);
        gpio_evt = 1; wifi_evt = 1; touch_evt = 1; ext0_pads = '0;
        w0 = wake_cnt; tick(3);
        check("R2 hiber ignores gpio/wifi/touch/pad", wake_cnt, w0);
        timer_evt = 1; @(negedge clk);
        check("R2 hiber timer wake", wake_cnt, w0 + 1);
        check("R2 hiber cause", last_cause, 11'h008);
        // R2 deep filter
        clear_src(); wake_en = 11'h7FF; ext0_pol = 1;
        gpio_evt = 1; sdio_evt = 1; wifi_evt = 1; bt_evt = 1;
        request(2'd2);
        check("R2 deep entered", asleep, 1);
        @(negedge clk);
        check("R2 deep cause gpio only", last_cause, 11'h004);

        // R5 serial threshold
        clear_src(); wake_en = 11'h040; uart_thresh = 10'd3;
        for (int i = 0; i < 6; i++) rx_pulse();
        request(2'd1);
        w0 = wake_cnt;
        for (int i = 0; i < 4; i++) rx_pulse();
        check("R5 four edges no wake", wake_cnt, w0);
        rx_pulse();
        check("R5 fifth edge wakes", wake_cnt, w0 + 1);
        check("R5 cause", last_cause, 11'h040);
        // R9 serial never refuses; counter cleared on entry
        rej_light_en = 1;
        request(2'd1);
        check("R9 serial no reject", asleep, 1);
        w0 = wake_cnt; tick(2);
        check("R5 counter cleared on entry", wake_cnt, w0);
        timer_wake("R5 timer exit");

        // R7 refusal
        clear_src(); wake_en = 11'h100; touch_evt = 1; rej_deep_en = 1;
        request(2'd2);
        check("R7 reject pulse", reject, 1);
        check("R7 reject cause", reject_cause, 11'h100);
        check("R7 stays awake", asleep, 0);
        @(negedge clk);
        check("R7 reject one cycle", reject, 0);
        // R7 hibernation: touch not valid so no refusal
        request(2'd3);
        check("R7 hiber touch no reject", asleep, 1);
        timer_wake("R7 timer exit");
        // R8 gate per mode
        clear_src(); wake_en = 11'h100; touch_evt = 1; rej_light_en = 1;
        request(2'd2);
        check("R8 deep gate off accepts", asleep, 1);
        check("R8 no reject", reject, 0);
        @(negedge clk);
        rej_light_en = 0; rej_deep_en = 1;
        request(2'd1);
        check("R8 light gate off accepts", asleep, 1);
        @(negedge clk);
        touch_evt = 0;

        // R10 requests ignored
        clear_src(); wake_en = 11'h008;
        request(2'd1);
        rej_light_en = 1; rej_deep_en = 1; touch_evt = 1; wake_en = 11'h108;
        wake_en = 11'h008;
        request(2'd2);
        check("R10 asleep request keeps asleep", asleep, 1);
        check("R10 asleep request no reject", reject, 0);
        timer_wake("R10 timer exit");
        clear_src();
        request(2'd0);
        check("R10 mode zero ignored", asleep, 0);

        // randomized
        for (int it = 0; it < 150; it++) begin
            logic [1:0]  m;
            logic [10:0] raw, rv, ht;
            logic        ron;
            clear_src();
            m = 2'($urandom_range(1, 3));
            wake_en = 11'($urandom);
            rej_light_en = 1'($urandom); rej_deep_en = 1'($urandom);
            ext0_pads = $urandom; ext0_sel = 5'($urandom); ext0_pol = 1'($urandom);
            ext1_pads = 18'($urandom); ext1_map = 18'($urandom & $urandom); ext1_pol = 1'($urandom);
            gpio_evt = ($urandom_range(0, 3) == 0); timer_evt = ($urandom_range(0, 3) == 0);
            sdio_evt = ($urandom_range(0, 3) == 0); wifi_evt = ($urandom_range(0, 3) == 0);
            touch_evt = ($urandom_range(0, 3) == 0); cop_evt = ($urandom_range(0, 3) == 0);
            bt_evt = ($urandom_range(0, 3) == 0);
            raw = model_raw();
            rv  = raw & wake_en & allow(m) & ~11'h0C0;
            ron = (m == 2'd1) ? rej_light_en : rej_deep_en;
            request(m);
            if (ron && rv != 0) begin
                check("R7 rand reject", reject, 1);
                check("R7 rand cause", reject_cause, rv);
                check("R7 rand awake", asleep, 0);
            end else begin
                check("R8 rand accept", asleep, 1);
                check("R8 rand no reject", reject, 0);
                ht = raw & wake_en & allow(m);
                if (ht == 0) begin
                    wake_en = 11'h7FF; timer_evt = 1;
                    ht = model_raw() & allow(m);
                end
                w0 = wake_cnt;
                @(negedge clk);
                check("R6 rand wake", wake_cnt, w0 + 1);
                check("R2 rand cause", last_cause, ht);
            end
            @(negedge clk);
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule